// File: doc/BRIEF.md
# Master Port Standby Gate

This block sits between a bus-mastering core and the system bus. It keeps the master port parked in standby from reset onwards and lets master requests through only once firmware has set up a small configuration register and the core has left its idle state. While standby is up, requests from the core are not lost. They wait at the gate and pass as soon as standby drops.

The configuration register has three fields. A force-enable bit sits at bit 0 and resets to 1. A two-bit slave idle-mode field sits at [4:3]. A two-bit master idle-mode field sits at [13:12], where the code 2'b01 means no-standby. Standby is released only when force-enable is 0, the master field holds 2'b01 and the core's idle indication is low. It comes back as soon as any of these stops holding. The slave field is stored and read back but does not steer standby. All other register bits read as 0.

Top module: `mstby_gate`

## Requirements
- R1: While reset is high, and in the first cycle after it, `standby_o` is 1 and `cfg_rdata` reads 16'h0001.
- R2: A write with `cfg_we`=1 stores bit 0, bits [4:3] and bits [13:12] of `cfg_wdata`, visible on `cfg_rdata` after the next rising edge. Every other bit of `cfg_rdata` reads 0.
- R3: When force-enable (bit 0) is 0, the master idle-mode field ([13:12]) is 2'b01 and `core_idle_i` is 0 at a rising edge, `standby_o` is 0 after that edge.
- R4: When force-enable is 1 at a rising edge, `standby_o` is 1 after that edge.
- R5: When the master idle-mode field holds any value other than 2'b01 at a rising edge, `standby_o` is 1 after that edge.
- R6: When `core_idle_i` is 1 at a rising edge, `standby_o` is 1 after that edge. This also reasserts a standby that had been released.
- R7: `mst_req_o` equals `core_req_i` AND NOT `standby_o` at all times. A request held high through standby appears on `mst_req_o` in the cycle standby drops.
- R8: The slave idle-mode field ([4:3]) has no effect on `standby_o`, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read-back, taken from the stored fields |
| core_idle_i | input | 1 | Core reports it is in its idle state |
| core_req_i | input | 1 | Raw master request from the core |
| standby_o | output | 1 | Master port in standby (registered) |
| mst_req_o | output | 1 | Master request passed to the bus |

## Verification
A register write shows on `cfg_rdata` after one rising edge. Its effect on `standby_o` shows one edge later, because standby is registered from the stored fields. A change of `core_idle_i` reaches `standby_o` after a single edge. `mst_req_o` follows `core_req_i` in the same cycle. The bench drives inputs on the falling edge and advances a reference model at each rising edge. It compares every output at the next falling edge, so each expected value is fixed by the model state of the edge that produced it.

// File: rtl/mstby_pkg.sv
package mstby_pkg;
  localparam int CFG_W      = 16;
  localparam int FORCE_BIT  = 0;
  localparam int SIDLE_LO   = 3;
  localparam int MIDLE_LO   = 12;
  localparam int MODE_W     = 2;
  localparam logic [MODE_W-1:0] MODE_NO_STANDBY = 2'b01;

  typedef struct packed {
    logic              force_en;
    logic [MODE_W-1:0] sidle;
    logic [MODE_W-1:0] midle;
  } cfg_t;
endpackage

// File: rtl/mstby_cfg_reg.sv
module mstby_cfg_reg
  import mstby_pkg::*;
#(
  parameter int W         = CFG_W,
  parameter int F_BIT     = FORCE_BIT,
  parameter int S_LO      = SIDLE_LO,
  parameter int M_LO      = MIDLE_LO,
  parameter bit FORCE_RST = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output cfg_t         cfg,
  output logic [W-1:0] rdata
);
  localparam logic [W-1:0] FIELD_MASK =
    (W'(1) << F_BIT) | (W'(3) << S_LO) | (W'(3) << M_LO);

  cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.force_en <= FORCE_RST;
      cfg_q.sidle    <= '0;
      cfg_q.midle    <= '0;
    end else if (we) begin
      cfg_q.force_en <= wdata[F_BIT];
      cfg_q.sidle    <= wdata[S_LO +: MODE_W];
      cfg_q.midle    <= wdata[M_LO +: MODE_W];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[F_BIT]            = cfg_q.force_en;
    rdata[S_LO +: MODE_W]   = cfg_q.sidle;
    rdata[M_LO +: MODE_W]   = cfg_q.midle;
  end

  assign cfg = cfg_q;

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdata & ~FIELD_MASK) == '0); // R2
endmodule

// File: rtl/mstby_standby_ctl.sv
module mstby_standby_ctl
  import mstby_pkg::*;
#(
  parameter logic [MODE_W-1:0] RELEASE_CODE = MODE_NO_STANDBY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              force_en,
  input  logic [MODE_W-1:0] midle,
  input  logic              core_idle,
  output logic              standby
);
  logic standby_q;
  logic release_ok;

  assign release_ok = !force_en && (midle == RELEASE_CODE) && !core_idle;

  always_ff @(posedge clk) begin
    if (rst) standby_q <= 1'b1;
    else     standby_q <= !release_ok;
  end

  assign standby = standby_q;

  AST_RESET_STANDBY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> standby); // R1
  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!force_en && midle == RELEASE_CODE && !core_idle) |=> !standby); // R3
  AST_FORCE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    force_en |=> standby); // R4
  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (midle != RELEASE_CODE) |=> standby); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    core_idle |=> standby); // R6
endmodule

// File: rtl/mstby_req_gate.sv
module mstby_req_gate (
  input  logic standby,
  input  logic core_req,
  output logic mst_req
);
  assign mst_req = core_req & ~standby;
endmodule

// File: rtl/mstby_gate.sv
module mstby_gate
  import mstby_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_we,
  input  logic [W-1:0] cfg_wdata,
  output logic [W-1:0] cfg_rdata,
  input  logic         core_idle_i,
  input  logic         core_req_i,
  output logic         standby_o,
  output logic         mst_req_o
);
  cfg_t cfg;
  logic standby;
  logic unused_sidle;

  mstby_cfg_reg #(.W(W)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  // The slave idle field only reaches read-back; it never steers standby.
  assign unused_sidle = ^cfg.sidle;

  mstby_standby_ctl u_stby (
    .clk       (clk),
    .rst       (rst),
    .force_en  (cfg.force_en),
    .midle     (cfg.midle),
    .core_idle (core_idle_i),
    .standby   (standby)
  );

  mstby_req_gate u_gate (
    .standby  (standby),
    .core_req (core_req_i),
    .mst_req  (mst_req_o)
  );

  assign standby_o = standby;

  AST_NO_REQ_IN_STANDBY: assert property (@(posedge clk) disable iff (rst)
    standby_o |-> !mst_req_o); // R7
  AST_REQ_PASSES: assert property (@(posedge clk) disable iff (rst)
    (!standby_o && core_req_i) |-> mst_req_o); // R7
endmodule

// File: tb/mstby_gate_tb.sv
`timescale 1ns/1ps
module mstby_gate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        core_idle_i = 1'b1;
  logic        core_req_i = 1'b0;
  logic        standby_o;
  logic        mst_req_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  logic       m_force = 1'b1;
  logic [1:0] m_sidle = '0;
  logic [1:0] m_midle = '0;
  logic       m_stby  = 1'b1;

  always #2 clk = ~clk;

  mstby_gate u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .core_idle_i(core_idle_i), .core_req_i(core_req_i),
    .standby_o(standby_o), .mst_req_o(mst_req_o)
  );

  function automatic logic [15:0] exp_rdata();
    return 16'(m_force) | (16'(m_sidle) << 3) | (16'(m_midle) << 12);
  endfunction

  function automatic logic next_stby(logic f, logic [1:0] mi, logic ci);
    return !(!f && mi == 2'b01 && !ci);
  endfunction

  function automatic string stby_tag(logic f, logic [1:0] mi, logic ci);
    if (f) return "R4";
    if (mi != 2'b01) return "R5";
    if (ci) return "R6";
    return "R3";
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, step a rising edge, compare at the following negedge
  task automatic step(logic we, logic [15:0] wd, logic ci, logic rq);
    string tag;
    cfg_we = we; cfg_wdata = wd; core_idle_i = ci; core_req_i = rq;
    @(posedge clk);
    tag = stby_tag(m_force, m_midle, ci);
    if (rst) m_stby = 1'b1;
    else     m_stby = next_stby(m_force, m_midle, ci);
    if (rst) begin m_force = 1'b1; m_sidle = '0; m_midle = '0; end
    else if (we) begin m_force = wd[0]; m_sidle = wd[4:3]; m_midle = wd[13:12]; end
    @(negedge clk);
    if (!rst) begin
      chk(tag, 16'(standby_o), 16'(m_stby));
      chk("R7", 16'(mst_req_o), 16'(rq & ~m_stby));
      chk("R2", cfg_rdata, exp_rdata());
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    @(negedge clk);
    step(1'b1, 16'h3019, 1'b0, 1'b1);
    step(1'b0, 16'h0000, 1'b0, 1'b1);
    chk("R1", 16'(standby_o), 16'h1);
    chk("R1", cfg_rdata, 16'h0001);
    rst = 1'b0;
    // first cycle after reset: force still 1, standby held
    step(1'b0, 16'h0, 1'b0, 1'b1);
    chk("R1", cfg_rdata, 16'h0001);
    // R2: unimplemented bits read 0
    step(1'b1, 16'hFFFE, 1'b1, 1'b1);
    chk("R2", cfg_rdata, 16'h3018);
    // R3: release, held request passes (R7)
    step(1'b1, 16'h1000, 1'b0, 1'b1);
    step(1'b0, 16'h0, 1'b0, 1'b1);
    chk("R3", 16'(standby_o), 16'h0);
    chk("R7", 16'(mst_req_o), 16'h1);
    // R6: core idle reasserts
    step(1'b0, 16'h0, 1'b1, 1'b1);
    chk("R6", 16'(standby_o), 16'h1);
    step(1'b0, 16'h0, 1'b0, 1'b0);
    // R8: every slave idle value keeps standby released
    for (int s = 0; s < 4; s++) begin
      step(1'b1, 16'h1000 | 16'(s << 3), 1'b0, 1'b0);
      step(1'b0, 16'h0, 1'b0, 1'b0);
      chk("R8", 16'(standby_o), 16'h0);
    end
    // R5: other master modes hold standby
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      step(1'b1, 16'(m << 12), 1'b0, 1'b1);
      step(1'b0, 16'h0, 1'b0, 1'b1);
      chk("R5", 16'(standby_o), 16'h1);
    end
    // R4: force bit holds standby
    step(1'b1, 16'h1001, 1'b0, 1'b1);
    step(1'b0, 16'h0, 1'b0, 1'b1);
    chk("R4", 16'(standby_o), 16'h1);
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] wd;
      wd = 16'($urandom);
      if ($urandom_range(0, 2) != 0) wd = (wd & 16'hCFFE) | 16'h1000;
      step($urandom_range(0, 5) == 0, wd, $urandom_range(0, 4) == 0,
           1'($urandom));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule